// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is an 8-bit up-counter that serves as a periodic interval timer or as a system watchdog. It sits behind a 16-bit register bus on which writes are protected. Only full-word writes are accepted. The upper byte of each write is a key, and the key decides which register, or which operation, the lower byte reaches. Software cannot change the timer by accident with a stray byte store or with a wrong key.

The counter advances on ticks from a free-running prescaler. A three-bit clock-select field picks the tick period, which is a power of two. When the counter overflows in interval mode, a sticky flag is set and an interrupt request goes to the CPU interrupt path. When it overflows in watchdog mode, a separate watchdog flag is set. If resets are enabled, a reset request pulse is also issued, and a kind bit tells the chip reset generator whether to perform a power-on style reset or a manual style reset.

Reads need no key. Each register has its own read address.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the bus reads 0x0018 at the control address (0), 0x0000 at the count address (1) and 0x001F at the reset-control address (2), and both intervalIrq and resetReq are low.
- R2: A write with busWordEn low is ignored at every address, whatever its data.
- R3: A word write to address 0 with upper byte 0x5A loads the lower byte into the counter, provided the timer is enabled. The counter read at address 1 then shows that value.
- R4: A word write to address 0 with upper byte 0xA5 writes the control register from the lower byte: bit 6 = mode (1 watchdog, 0 interval), bit 5 = enable, bits 2:0 = clock select. On the same write, lower bit 7 = 0 clears the interval flag and bit 7 = 1 leaves it unchanged. Any other upper byte at address 0 is ignored.
- R5: While enable is 1 with clock select s, the counter advances by one every 2^(s*DIV_STEP) cycles and wraps from 0xFF to 0x00. The wrap is the overflow. While enable is 0 the counter reads 0 and counter writes have no effect.
- R6: In interval mode an overflow sets control bit 7 (the interval flag). intervalIrq follows that flag and stays high until software clears it. An overflow in the same cycle as a clear leaves the flag set.
- R7: In watchdog mode an overflow sets reset-control bit 7 (the watchdog flag). If reset-control bit 6 (reset enable) is 1, resetReq is also high for RST_PULSE cycles starting with the overflow edge. During the pulse, resetKind carries reset-control bit 5 as it was at the overflow (0 power-on, 1 manual). If reset enable is 0, no pulse is issued.
- R8: At address 2, upper byte 0xA5 with lower byte 0x00 clears the watchdog flag and leaves bits 6 and 5 unchanged. Upper byte 0x5A copies lower bits 6 and 5 into reset enable and reset kind and leaves the watchdog flag unchanged. Any other key, or 0xA5 with a nonzero lower byte, is ignored.
- R9: Reads return zero in the upper byte. Reserved control bits 4:3 and reset-control bits 4:0 read as 1. Unmapped addresses read 0x0000, and writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register word address for reads and writes |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWordEn | input | 1 | 1 = 16-bit word access, 0 = byte access |
| busWrData | input | 16 | Write data: key in the upper byte, value in the lower byte |
| busRdData | output | 16 | Read data for busAddr |
| intervalIrq | output | 1 | Interval interrupt request to the CPU interrupt path |
| resetReq | output | 1 | Reset request pulse to the chip reset generator |
| resetKind | output | 1 | Kind of reset requested: 0 power-on, 1 manual |

## Verification
The bench builds the block with DIV_STEP = 1, so clock selects 0 to 7 give tick periods of 1 to 128 cycles. Overflows at the fast selects therefore come within a few hundred cycles, and the prescaler masking at slow selects is still exercised. RST_PULSE is set to 5, so both the start and the end of each reset pulse fall inside short waiting windows, and a second watchdog overflow can re-arm the pulse. Counter preloads near 0xFF place overflows next to keyed clears, which brings the set-wins-over-clear race within reach.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam logic [7:0] KEY_CTRL  = 8'hA5;

  typedef struct packed {
    logic       wrCnt;
    logic       wrCsr;
    logic       clrWd;
    logic       wrRst;
    logic [7:0] data;
  } strobe_t;
endpackage

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ADDR_SHARED = 0,
  parameter int ADDR_RST    = 2
) (
  input  logic              busWrEn,
  input  logic              busWordEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  output strobe_t           strb
);
  logic       wordWr;
  logic       atShared;
  logic       atRst;
  logic [7:0] key;
  logic [7:0] lo;

  always_comb begin
    wordWr   = busWrEn && busWordEn;
    atShared = wordWr && (busAddr == ADDR_W'(ADDR_SHARED));
    atRst    = wordWr && (busAddr == ADDR_W'(ADDR_RST));
    key      = busWrData[15:8];
    lo       = busWrData[7:0];

    strb.data  = lo;
    strb.wrCnt = atShared && (key == KEY_COUNT);
    strb.wrCsr = atShared && (key == KEY_CTRL);
    strb.clrWd = atRst && (key == KEY_CTRL) && (lo == 8'h00);
    strb.wrRst = atRst && (key == KEY_COUNT);
  end
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ADDR_SHARED = 0,
  parameter int ADDR_CNT    = 1,
  parameter int ADDR_RST    = 2,
  parameter int DIV_STEP    = 1,
  parameter int RST_PULSE   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busRdData,
  output logic              intervalIrq,
  output logic              resetReq,
  output logic              resetKind,
  output logic [7:0]        cntVal,
  output logic              runEn,
  output logic              wdFlag
);
  localparam int SEL_W   = 3;
  localparam int SEL_MAX = (1 << SEL_W) - 1;
  localparam int PRE_W   = SEL_MAX * DIV_STEP;
  localparam int PULSE_W = $clog2(RST_PULSE + 1);

  logic [7:0]         cnt;
  logic [PRE_W-1:0]   pre;
  logic [PRE_W-1:0]   preMask;
  logic [SEL_W-1:0]   clkSel;
  logic               ivFlag;
  logic               modeWd;
  logic               runEnR;
  logic               rstEn;
  logic               rstSel;
  logic               wdFlagR;
  logic               kindR;
  logic [PULSE_W-1:0] pulse;
  logic               enNext;
  logic               tick;
  logic               ovf;

  // Prescaler bits below s*DIV_STEP must all be 1 for a tick.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign preMask[i] = (i < int'(clkSel) * DIV_STEP);
  end

  always_comb begin
    enNext = strb.wrCsr ? strb.data[5] : runEnR;
    tick   = runEnR && (&(pre | ~preMask));
    ovf    = tick && (cnt == 8'hFF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= enNext ? pre + 1'b1 : '0;
      if (!enNext)         cnt <= '0;
      else if (strb.wrCnt) cnt <= strb.data;
      else if (tick)       cnt <= cnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWd <= 1'b0;
      runEnR <= 1'b0;
      clkSel <= '0;
      ivFlag <= 1'b0;
    end else begin
      if (strb.wrCsr) begin
        modeWd <= strb.data[6];
        runEnR <= strb.data[5];
        clkSel <= strb.data[SEL_W-1:0];
      end
      if (ovf && !modeWd)                    ivFlag <= 1'b1;
      else if (strb.wrCsr && !strb.data[7])  ivFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdFlagR <= 1'b0;
      rstEn   <= 1'b0;
      rstSel  <= 1'b0;
      pulse   <= '0;
      kindR   <= 1'b0;
    end else begin
      if (ovf && modeWd)   wdFlagR <= 1'b1;
      else if (strb.clrWd) wdFlagR <= 1'b0;
      if (strb.wrRst) begin
        rstEn  <= strb.data[6];
        rstSel <= strb.data[5];
      end
      if (ovf && modeWd && rstEn) begin
        pulse <= PULSE_W'(RST_PULSE);
        kindR <= rstSel;
      end else if (pulse != '0) begin
        pulse <= pulse - 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = 16'h0000;
    if (busAddr == ADDR_W'(ADDR_SHARED))
      busRdData[7:0] = {ivFlag, modeWd, runEnR, 2'b11, clkSel};
    else if (busAddr == ADDR_W'(ADDR_CNT))
      busRdData[7:0] = cnt;
    else if (busAddr == ADDR_W'(ADDR_RST))
      busRdData[7:0] = {wdFlagR, rstEn, rstSel, 5'b11111};
  end

  assign intervalIrq = ivFlag;
  assign resetReq    = (pulse != '0);
  assign resetKind   = kindR;
  assign cntVal      = cnt;
  assign runEn       = runEnR;
  assign wdFlag      = wdFlagR;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ADDR_SHARED = 0,
  parameter int ADDR_CNT    = 1,
  parameter int ADDR_RST    = 2,
  parameter int DIV_STEP    = 1,
  parameter int RST_PULSE   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busWordEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  output logic              intervalIrq,
  output logic              resetReq,
  output logic              resetKind
);
  strobe_t    strb;
  logic [7:0] cntVal;
  logic       runEn;
  logic       wdFlag;

  keyed_wdog_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_SHARED(ADDR_SHARED), .ADDR_RST(ADDR_RST)
  ) u_ctrl (
    .busWrEn(busWrEn), .busWordEn(busWordEn), .busAddr(busAddr),
    .busWrData(busWrData), .strb(strb)
  );

  keyed_wdog_dp #(
    .ADDR_W(ADDR_W), .ADDR_SHARED(ADDR_SHARED), .ADDR_CNT(ADDR_CNT),
    .ADDR_RST(ADDR_RST), .DIV_STEP(DIV_STEP), .RST_PULSE(RST_PULSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busRdData(busRdData), .intervalIrq(intervalIrq), .resetReq(resetReq),
    .resetKind(resetKind), .cntVal(cntVal), .runEn(runEn), .wdFlag(wdFlag)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ADDR_SHARED = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busWordEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        wrKey,
  input logic              wrBit7,
  input logic              intervalIrq,
  input logic              resetReq,
  input strobe_t           strb,
  input logic [7:0]        cntVal,
  input logic              runEn,
  input logic              wdFlag
);
  logic ivClear;
  assign ivClear = busWrEn && busWordEn && (busAddr == ADDR_W'(ADDR_SHARED))
                   && (wrKey == KEY_CTRL) && !wrBit7;

  AST_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busWordEn) |-> (!strb.wrCnt && !strb.wrCsr && !strb.clrWd && !strb.wrRst)); // R2

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCnt, strb.wrCsr, strb.clrWd, strb.wrRst})); // R4

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (cntVal == 8'h00)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intervalIrq && !ivClear) |=> intervalIrq); // R6

  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> wdFlag); // R7
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W), .ADDR_SHARED(ADDR_SHARED)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordEn(busWordEn),
  .busAddr(busAddr), .wrKey(busWrData[15:8]), .wrBit7(busWrData[7]),
  .intervalIrq(intervalIrq), .resetReq(resetReq), .strb(strb),
  .cntVal(cntVal), .runEn(runEn), .wdFlag(wdFlag)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int PULSE      = 5;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busWordEn = 1'b0;
  logic [15:0]       busWrData = '0;
  logic [15:0]       busRdData;
  logic              intervalIrq;
  logic              resetReq;
  logic              resetKind;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.ADDR_W(ADDR_W), .DIV_STEP(1), .RST_PULSE(PULSE)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWordEn(busWordEn), .busWrData(busWrData), .busRdData(busRdData),
    .intervalIrq(intervalIrq), .resetReq(resetReq), .resetKind(resetKind)
  );

  // Reference state built from the requirements
  logic [7:0] mCnt;
  logic [6:0] mPre;
  logic [2:0] mCs;
  logic       mIv, mMode, mEn, mWd, mRe, mRs, mKind;
  int         mPulse;

  function automatic logic [15:0] modelRead(input logic [ADDR_W-1:0] a);
    case (a)
      0:       return {8'h00, mIv, mMode, mEn, 2'b11, mCs};
      1:       return {8'h00, mCnt};
      2:       return {8'h00, mWd, mRe, mRs, 5'h1F};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mCs = 0; mIv = 0; mMode = 0; mEn = 0;
      mWd = 0; mRe = 0; mRs = 0; mKind = 0; mPulse = 0;
    end else begin
      logic ww, wc, wcsr, clr, wrb, enN, tk, ov;
      logic [7:0] hi, lo;
      logic [6:0] m;
      hi = busWrData[15:8];
      lo = busWrData[7:0];
      ww   = busWrEn && busWordEn;
      wc   = ww && busAddr == 0 && hi == 8'h5A;
      wcsr = ww && busAddr == 0 && hi == 8'hA5;
      clr  = ww && busAddr == 2 && hi == 8'hA5 && lo == 8'h00;
      wrb  = ww && busAddr == 2 && hi == 8'h5A;
      enN  = wcsr ? lo[5] : mEn;
      m    = 7'((1 << mCs) - 1);
      tk   = mEn && ((mPre & m) == m);
      ov   = tk && mCnt == 8'hFF;
      if (ov && mMode && mRe) begin mPulse = PULSE; mKind = mRs; end
      else if (mPulse != 0) mPulse = mPulse - 1;
      if (ov && mMode) mWd = 1'b1; else if (clr) mWd = 1'b0;
      if (wrb) begin mRe = lo[6]; mRs = lo[5]; end
      if (ov && !mMode) mIv = 1'b1; else if (wcsr && !lo[7]) mIv = 1'b0;
      if (!enN) mCnt = 0; else if (wc) mCnt = lo; else if (tk) mCnt = mCnt + 1;
      mPre = enN ? mPre + 1 : 0;
      if (wcsr) begin mMode = lo[6]; mEn = lo[5]; mCs = lo[2:0]; end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output pins compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(intervalIrq == mIv, "R6 intervalIrq", 16'(intervalIrq), 16'(mIv));
      check(resetReq == (mPulse != 0), "R7 resetReq", 16'(resetReq), 16'(mPulse != 0));
      if (mPulse != 0)
        check(resetKind == mKind, "R7 resetKind", 16'(resetKind), 16'(mKind));
    end
  end

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic word);
    @(negedge clk);
    busAddr = a; busWrData = d; busWordEn = word; busWrEn = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic readCheck(input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = a;
    #1;
    check(busRdData == modelRead(a), tag, busRdData, modelRead(a));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values, with literal expectations
    busAddr = 0; #1; check(busRdData == 16'h0018, "R1 ctrl reset", busRdData, 16'h0018);
    busAddr = 1; #1; check(busRdData == 16'h0000, "R1 count reset", busRdData, 16'h0000);
    busAddr = 2; #1; check(busRdData == 16'h001F, "R1 rstctl reset", busRdData, 16'h001F);
    readCheck(3, "R9 unmapped read");
    // R2 byte writes ignored
    doWrite(0, 16'hA527, 1'b0); readCheck(0, "R2 byte ctrl");
    doWrite(2, 16'h5A60, 1'b0); readCheck(2, "R2 byte rstctl");
    // R4 wrong key
    doWrite(0, 16'h3327, 1'b1); readCheck(0, "R4 bad key");
    // R9 write to count read address ignored
    doWrite(1, 16'h5A77, 1'b1); readCheck(1, "R9 count addr write");
    // R4/R5 enable interval mode, select 0
    doWrite(0, 16'hA520, 1'b1); readCheck(0, "R4 ctrl write");
    doWrite(0, 16'h5AFC, 1'b1); readCheck(1, "R3 count load");
    idle(3); readCheck(1, "R5 counting");
    idle(6); readCheck(0, "R6 flag set");
    idle(300); readCheck(0, "R6 flag held");
    doWrite(0, 16'hA5A0, 1'b1); readCheck(0, "R4 bit7 one keeps flag");
    doWrite(0, 16'hA520, 1'b1); readCheck(0, "R6 flag cleared");
    // R5 slower select
    doWrite(0, 16'hA523, 1'b1); doWrite(0, 16'h5A10, 1'b1);
    idle(17); readCheck(1, "R5 select 3");
    // R6 set wins over clear in the same cycle
    doWrite(0, 16'hA520, 1'b1); doWrite(0, 16'h5AFF, 1'b1); doWrite(0, 16'hA520, 1'b1);
    readCheck(0, "R6 set beats clear");
    doWrite(0, 16'hA520, 1'b1);
    // R7 watchdog mode, manual kind
    doWrite(2, 16'h5A60, 1'b1); readCheck(2, "R8 enable bits");
    doWrite(0, 16'hA560, 1'b1); doWrite(0, 16'h5AFE, 1'b1);
    idle(10); readCheck(2, "R7 watchdog flag");
    readCheck(0, "R7 interval flag untouched");
    doWrite(2, 16'hA501, 1'b1); readCheck(2, "R8 nonzero low ignored");
    doWrite(2, 16'hA500, 1'b1); readCheck(2, "R8 flag clear keeps bits");
    doWrite(2, 16'h5A00, 1'b1); readCheck(2, "R8 bits write keeps flag");
    doWrite(0, 16'h5AFE, 1'b1); idle(10); readCheck(2, "R7 no pulse when disabled");
    // R5 disabled: held at zero, load ignored
    doWrite(0, 16'hA500, 1'b1); readCheck(1, "R5 held zero");
    doWrite(0, 16'h5A40, 1'b1); readCheck(1, "R5 load ignored when off");
    // Random phase
    for (int it = 0; it < 600; it++) begin
      int r;
      logic [ADDR_W-1:0] a;
      logic [7:0] key, lo;
      r = $urandom_range(0, 99);
      a = (r < 45) ? 0 : (r < 80) ? 2 : ADDR_W'($urandom_range(1, 4));
      r = $urandom_range(0, 9);
      key = (r < 4) ? 8'h5A : (r < 8) ? 8'hA5 : 8'($urandom);
      if (a == 0 && key == 8'hA5)
        lo = {1'($urandom), 1'($urandom), ($urandom_range(0, 9) < 8), 2'b00, 3'($urandom_range(0, 2))};
      else if (a == 0)
        lo = 8'hF0 | 8'($urandom_range(0, 15));
      else if (a == 2 && key == 8'hA5)
        lo = ($urandom_range(0, 3) != 0) ? 8'h00 : 8'($urandom);
      else
        lo = 8'($urandom);
      doWrite(a, {key, lo}, $urandom_range(0, 9) != 0);
      idle($urandom_range(0, 20));
      readCheck(ADDR_W'($urandom_range(0, 3)), "R9 random read");
    end
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule